// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Clear-to-Send Gating

This block turns characters written by a host into asynchronous serial frames on a single output line. A one-character holding register sits in front of a frame shift register. The host may therefore queue the next character while the current one is still leaving the line. Each frame opens with a low start bit, and data bits follow least significant bit first. The data field is 7, 8 or 9 bits wide. An optional even or odd parity bit comes next, and one or two high stop bits close the frame. Every bit lasts 16*(n+1) clock cycles, where n is an 8-bit divisor input.

A new frame begins only when three things are true: the transmitter is enabled, the holding register holds a character, and, if flow control is switched on, the synchronized clear-to-send input is low. Clear-to-send is only looked at when a frame is about to start. A frame that has already begun always runs to its last stop bit.

The interrupt request output gives a one-cycle pulse. A select input chooses when it fires. It can fire when the holding register is handed to the shift register, or only once the last stop bit has left the line.

Top module: `sertx_dbuf`

## Requirements
- R1: After reset `txd` is 1, `buf_empty` is 1 and `irq` is 0. Whenever no frame is in progress, `txd` stays 1.
- R2: A frame starts with one 0 bit. The data bits follow, least significant bit first. The data width comes from `width_code`: 0 selects 7 bits, 2 selects 9 bits, and 1 or 3 select 8 bits.
- R3: `par_code` 1 appends an even parity bit, equal to the XOR of the data bits. `par_code` 2 appends an odd parity bit, equal to the inverse of that XOR. `par_code` 0 or 3 sends no parity bit.
- R4: The frame ends with one stop bit of value 1 when `two_stop` is 0, and two stop bits when it is 1.
- R5: Every bit of a frame lasts 16*(`div_n`+1) clock cycles. The divisor is captured when the frame starts. The start bit appears on `txd` in the cycle after the loading edge.
- R6: A write with `wr_en` high while `buf_empty` is 1 is accepted, and `buf_empty` reads 0 from the next cycle. A write while `buf_empty` is 0 is ignored. `buf_empty` returns to 1 in the cycle after the character moves into the shift register.
- R7: No frame starts while `tx_en` is 0. A held character starts at the first clock edge at which `tx_en` is 1.
- R8: With `cts_en` 1, a held character waits while `cts_n` is high. After `cts_n` falls, the load happens at the third rising clock edge, because the input passes through two flops first. With `cts_en` 0, `cts_n` is ignored.
- R9: A rise of `cts_n` after a frame has started does not shorten or change that frame.
- R10: With `irq_sel` 0, `irq` pulses high for exactly one cycle, namely the cycle right after the edge that loads the shift register.
- R11: With `irq_sel` 1, `irq` pulses high for exactly one cycle, namely the cycle right after the edge that ends the last stop bit.
- R12: If a character is waiting when a frame's last stop bit ends, its start bit follows at once with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the bit-rate source |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Allows frames to start |
| cts_en | input | 1 | Enables clear-to-send gating |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| irq_sel | input | 1 | 0: interrupt on load, 1: interrupt on frame end |
| div_n | input | 8 | Bit-rate divisor n; bit time is 16*(n+1) cycles |
| width_code | input | 2 | Data width select (0:7, 1:8, 2:9, 3:8) |
| par_code | input | 2 | Parity select (0:none, 1:even, 2:odd, 3:none) |
| two_stop | input | 1 | 1 selects two stop bits |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 9 | Character to send; unused upper bits are ignored |
| buf_empty | output | 1 | Holding register can accept a write |
| txd | output | 1 | Serial output, idle high |
| irq | output | 1 | One-cycle interrupt request pulse |

## Verification
If the remaining-bit count goes wrong, the frame length on `txd` changes. A frame that is too long or too short then moves the final stop-bit edge and the `irq_sel`=1 pulse by whole bit times, and this shows within that frame. A wrong holding-register flag shows at once. `buf_empty` would stay low after the load edge, or a second write would replace a queued character, and the next frame would then carry the wrong data bits. Faults in the clear-to-send path show up as a start that comes several cycles too early or too late. Faults in the rate counter stretch every bit and break the mid-bit samples within a single bit time.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   localparam int DATA_W = 9;

   typedef struct packed {
      logic [1:0] width_code;
      logic [1:0] par_code;
      logic       two_stop;
   } fmt_t;

   function automatic int data_len(input logic [1:0] code);
      case (code)
         2'd0:    return 7;
         2'd2:    return 9;
         default: return 8;
      endcase
   endfunction

   function automatic logic parity_on(input logic [1:0] code);
      return (code == 2'd1) || (code == 2'd2);
   endfunction

endpackage

// File: rtl/sertx_sync.sv
module sertx_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sertx_sync needs at least two stages");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sertx_rate.sv
module sertx_rate #(
   parameter int DIV_W = 8,
   parameter int OVS   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             bit_end
);
   localparam int OVS_W = $clog2(OVS);
   localparam int CNT_W = DIV_W + OVS_W + 1;

   if (OVS < 2) begin : g_bad_ovs
      $error("sertx_rate oversampling factor must be at least 2");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] divp1;
   logic [CNT_W-1:0] last;

   assign divp1 = CNT_W'(div) + CNT_W'(1);

   if ((OVS & (OVS - 1)) == 0) begin : g_pow2
      assign last = (divp1 << OVS_W) - CNT_W'(1);
   end else begin : g_mult
      assign last = divp1 * CNT_W'(OVS) - CNT_W'(1);
   end

   assign bit_end = run && (cnt == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else if (run)     cnt <= bit_end ? '0 : cnt + CNT_W'(1);
   end

   // R5: the phase counter never passes the end of a bit period
   p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> cnt <= last);
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
   import sertx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] data,
   input  fmt_t              fmt,
   input  logic              bit_end,
   output logic              txd,
   output logic              busy,
   output logic              frame_done
);
   localparam int FW = DATA_W + 3;
   localparam int LW = $clog2(FW + 2);

   logic [FW-1:0] body;
   logic [FW-1:0] sreg;
   logic [LW-1:0] left;
   logic [LW-1:0] left_init;

   always_comb begin
      int  dl;
      logic pbit;
      body = '1;
      dl   = data_len(fmt.width_code);
      pbit = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
         if (i < dl) begin
            body[i] = data[i];
            pbit    = pbit ^ data[i];
         end
      end
      if (parity_on(fmt.par_code)) begin
         body[dl] = (fmt.par_code == 2'd2) ? ~pbit : pbit;
      end
      left_init = LW'(dl + (parity_on(fmt.par_code) ? 1 : 0) + (fmt.two_stop ? 2 : 1));
   end

   assign frame_done = busy && bit_end && (left == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg <= '1;
         left <= '0;
         txd  <= 1'b1;
         busy <= 1'b0;
      end else if (load) begin
         sreg <= body;
         left <= left_init;
         txd  <= 1'b0;
         busy <= 1'b1;
      end else if (frame_done) begin
         busy <= 1'b0;
         txd  <= 1'b1;
      end else if (busy && bit_end) begin
         txd  <= sreg[0];
         sreg <= {1'b1, sreg[FW-1:1]};
         left <= left - LW'(1);
      end
   end

   // R1: line stays high with no frame in progress
   p_idle_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);
   // R2: every new frame opens with a low start bit
   p_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !txd);
   // R4: the bit ending a frame is a high stop bit
   p_stop_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> txd);
endmodule

// File: rtl/sertx_dbuf.sv
module sertx_dbuf
   import sertx_pkg::*;
#(
   parameter int DIV_W    = 8,
   parameter int OVS      = 16,
   parameter int CTS_SYNC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              cts_en,
   input  logic              cts_n,
   input  logic              irq_sel,
   input  logic [DIV_W-1:0]  div_n,
   input  logic [1:0]        width_code,
   input  logic [1:0]        par_code,
   input  logic              two_stop,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              buf_empty,
   output logic              txd,
   output logic              irq
);
   logic              buf_full;
   logic [DATA_W-1:0] buf_q;
   logic [DIV_W-1:0]  div_q;
   logic              cts_s;
   logic              busy;
   logic              frame_done;
   logic              bit_end;
   logic              load;
   logic              irq_q;
   fmt_t              fmt;

   assign fmt = '{width_code: width_code, par_code: par_code, two_stop: two_stop};

   sertx_sync #(.STAGES(CTS_SYNC), .RST_VAL(1'b1)) u_cts (
      .clk(clk), .rst_n(rst_n), .d(cts_n), .q(cts_s));

   assign load = buf_full && tx_en && (!cts_en || !cts_s) && (!busy || frame_done);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_full <= 1'b0;
         buf_q    <= '0;
         div_q    <= '0;
         irq_q    <= 1'b0;
      end else begin
         if (load) begin
            buf_full <= 1'b0;
            div_q    <= div_n;
         end else if (wr_en && !buf_full) begin
            buf_full <= 1'b1;
            buf_q    <= wr_data;
         end
         irq_q <= irq_sel ? frame_done : load;
      end
   end

   sertx_rate #(.DIV_W(DIV_W), .OVS(OVS)) u_rate (
      .clk(clk), .rst_n(rst_n), .restart(load), .run(busy),
      .div(div_q), .bit_end(bit_end));

   sertx_shift u_shift (
      .clk(clk), .rst_n(rst_n), .load(load), .data(buf_q), .fmt(fmt),
      .bit_end(bit_end), .txd(txd), .busy(busy), .frame_done(frame_done));

   assign buf_empty = !buf_full;
   assign irq       = irq_q;

   // R6: a held character is neither replaced nor lost until it loads
   p_full_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      buf_full && !load |=> $stable(buf_q) && !buf_empty);
   // R7: transmitter disabled keeps an idle line idle
   p_tx_en_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en && !busy |=> !busy);
   // R8: synchronized clear-to-send high blocks a start
   p_cts_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cts_en && cts_s && !busy |=> !busy);
   // R10: load-cause interrupt accompanies each new frame
   p_irq_on_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) && !$past(irq_sel) |-> irq);
   // R10, R11: the request is a single-cycle pulse
   p_irq_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !busy |=> !irq);
endmodule

// File: tb/sertx_dbuf_test.sv
`timescale 1ns/1ps
module sertx_dbuf_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_en = 1'b1, cts_en = 1'b0, cts_n = 1'b1, irq_sel = 1'b0;
   logic [7:0] div_n = 8'd0;
   logic [1:0] width_code = 2'd1, par_code = 2'd0;
   logic       two_stop = 1'b0, wr_en = 1'b0;
   logic [8:0] wr_data = '0;
   logic       buf_empty, txd, irq;

   int n_chk = 0, n_fail = 0, cyc = 0, irq_cnt = 0, irq_at = -1, last_e1 = 0;
   bit done = 0;

   always #10 clk = ~clk;

   sertx_dbuf uut (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cts_en(cts_en), .cts_n(cts_n),
      .irq_sel(irq_sel), .div_n(div_n), .width_code(width_code),
      .par_code(par_code), .two_stop(two_stop), .wr_en(wr_en),
      .wr_data(wr_data), .buf_empty(buf_empty), .txd(txd), .irq(irq));

   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) if (irq) begin irq_cnt++; irq_at = cyc; end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int per();
      return 16 * (int'(div_n) + 1);
   endfunction

   function automatic int flen();
      int dl = (width_code == 2'd0) ? 7 : (width_code == 2'd2) ? 9 : 8;
      return 1 + dl + ((par_code == 2'd1 || par_code == 2'd2) ? 1 : 0) + (two_stop ? 2 : 1);
   endfunction

   function automatic logic [12:0] fbits(input logic [8:0] d);
      logic [12:0] b = '1;
      int dl = (width_code == 2'd0) ? 7 : (width_code == 2'd2) ? 9 : 8;
      logic x = 1'b0;
      b[0] = 1'b0;
      for (int i = 0; i < dl; i++) begin b[1+i] = d[i]; x ^= d[i]; end
      if (par_code == 2'd1) b[1+dl] = x;
      if (par_code == 2'd2) b[1+dl] = ~x;
      return b;
   endfunction

   task automatic write(input logic [8:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(posedge clk);
      @(negedge clk); wr_en = 1'b0;
   endtask

   // caller is positioned at the edge half a bit after the loading edge
   task automatic expect_frame(input logic [8:0] d, input string req);
      logic [12:0] b = fbits(d);
      int p = per();
      for (int k = 0; k < flen(); k++) begin
         @(negedge clk);
         if (k == 0) begin
            last_e1 = cyc - p / 2;
            chk(buf_empty == 1'b1, "R6", "buffer freed at load", buf_empty, 1);
         end
         chk(txd == b[k], req, $sformatf("frame bit %0d", k), txd, b[k]);
         repeat (p) @(posedge clk);
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(txd == 1'b1, "R1", "reset txd", txd, 1);
      chk(buf_empty == 1'b1, "R1", "reset buf_empty", buf_empty, 1);
      chk(irq == 1'b0, "R1", "reset irq", irq, 0);
   endtask

   task automatic t_8n1;
      int c0 = irq_cnt;
      width_code = 2'd1; par_code = 2'd0; two_stop = 1'b0; irq_sel = 1'b0; div_n = 8'd0;
      write(9'h0A5);
      chk(buf_empty == 1'b0, "R6", "flag after write", buf_empty, 0);
      @(posedge clk); repeat (per() / 2) @(posedge clk);
      expect_frame(9'h0A5, "R2 R5 8N1");
      chk(irq_cnt == c0 + 1, "R10", "irq count", irq_cnt - c0, 1);
      chk(irq_at == last_e1, "R10", "irq cycle", irq_at, last_e1);
      @(negedge clk);
      chk(txd == 1'b1, "R1", "idle after frame", txd, 1);
   endtask

   task automatic t_7o2;
      int c0 = irq_cnt;
      width_code = 2'd0; par_code = 2'd2; two_stop = 1'b1; irq_sel = 1'b1; div_n = 8'd1;
      write(9'h035);
      @(posedge clk); repeat (per() / 2) @(posedge clk);
      expect_frame(9'h035, "R3 R4 R5 7O2");
      chk(irq_cnt == c0 + 1, "R11", "irq count", irq_cnt - c0, 1);
      chk(irq_at == last_e1 + flen() * per(), "R11", "irq cycle", irq_at, last_e1 + flen() * per());
   endtask

   task automatic t_9e1;
      width_code = 2'd2; par_code = 2'd1; two_stop = 1'b0; irq_sel = 1'b0; div_n = 8'd0;
      write(9'h1C3);
      @(posedge clk); repeat (per() / 2) @(posedge clk);
      expect_frame(9'h1C3, "R2 R3 9E1");
      width_code = 2'd3; par_code = 2'd3;
      write(9'h13C);
      @(posedge clk); repeat (per() / 2) @(posedge clk);
      expect_frame(9'h13C, "R2 R3 codes 3");
   endtask

   task automatic t_txen;
      int c0 = irq_cnt;
      width_code = 2'd1; par_code = 2'd0; div_n = 8'd0; tx_en = 1'b0;
      write(9'h05A);
      repeat (2 * per()) @(posedge clk);
      @(negedge clk);
      chk(txd == 1'b1 && buf_empty == 1'b0, "R7", "held while disabled", {txd, buf_empty}, 2);
      chk(irq_cnt == c0, "R7", "no irq while disabled", irq_cnt - c0, 0);
      tx_en = 1'b1;
      @(posedge clk); repeat (per() / 2) @(posedge clk);
      expect_frame(9'h05A, "R7 start on enable");
   endtask

   task automatic t_cts;
      cts_en = 1'b1; cts_n = 1'b1;
      repeat (4) @(posedge clk);
      write(9'h0C7);
      repeat (3 * per()) @(posedge clk);
      @(negedge clk);
      chk(txd == 1'b1 && buf_empty == 1'b0, "R8", "held by cts", {txd, buf_empty}, 2);
      cts_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(txd == 1'b1, "R8", "not yet started after two edges", txd, 1);
      @(posedge clk); repeat (per() / 2) @(posedge clk);
      fork
         expect_frame(9'h0C7, "R8 R9 cts");
         begin repeat (3 * per()) @(posedge clk); @(negedge clk); cts_n = 1'b1; end
      join
      cts_en = 1'b0;
      write(9'h081);
      @(posedge clk); repeat (per() / 2) @(posedge clk);
      expect_frame(9'h081, "R8 cts disabled");
   endtask

   task automatic t_b2b;
      width_code = 2'd1; par_code = 2'd0; two_stop = 1'b0; irq_sel = 1'b0; div_n = 8'd0;
      write(9'h033);
      @(posedge clk); repeat (per() / 2) @(posedge clk);
      fork
         expect_frame(9'h033, "R12 first");
         begin
            repeat (2 * per()) @(posedge clk);
            write(9'h0E1);
            repeat (per()) @(posedge clk);
            write(9'h0FF);
         end
      join
      expect_frame(9'h0E1, "R6 R12 queued");
      repeat (2 * per()) @(posedge clk);
      @(negedge clk);
      chk(txd == 1'b1, "R6", "write while full dropped", txd, 1);
      chk(buf_empty == 1'b1, "R6", "buffer empty at end", buf_empty, 1);
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_8n1();
      t_7o2();
      t_9e1();
      t_txen();
      t_cts();
      t_b2b();
      done = 1;
      summary();
   end

   always @(posedge clk) begin
      if (!done && cyc > 150000) begin
         done = 1;
         chk(1'b0, "R1", "watchdog expired", cyc, 150000);
         summary();
      end
   end
endmodule